// File: doc/BRIEF.md
# Two-Wire Bus Register Slave

This block lets a bus master on a two-wire serial bus (a clock line and a data line) read and write a small bank of byte registers. The block oversamples both lines with the system clock and finds the frame delimiters. It checks the 7-bit device address and acknowledges each byte that belongs to it. Within a write frame, the first data byte selects the register. Every later byte is stored at the selected register, and the register pointer then advances.

A read frame streams bytes out, starting at the current pointer. The stream continues for as long as the master acknowledges. It ends when the master leaves the acknowledge bit high. The data line is never driven high: the block only produces an enable that pulls the line low. The bus data line is therefore the wired AND of all pull-downs.

The register bank is internal to the block, and the bus is its only access path. The system clock must run at least ten times the bus clock rate.

Top module: `twi_slave_regs`

## Requirements
- R1: A START (data line falling while the clock line is high) begins address reception from any state, including a repeated START with no STOP before it. A STOP (data line rising while the clock line is high) returns the block to idle with the data line released.
- R2: Incoming bits are taken on the rising edge of the clock line. The pull-down enable changes only while the clock line is low and stays constant for the whole high phase.
- R3: The address byte carries 7 address bits MSB first, followed by a direction bit (1 = read, 0 = write). If the address equals DEV_ADDR (default 7'h5A), the block pulls the data line low during the ninth clock. On any other address it does not acknowledge and ignores the bus until the next START.
- R4: In a write frame, the first byte after the address loads the pointer from its low log2(REG_COUNT) bits. Each later byte is stored at the pointer, and the pointer then advances. Every byte of an addressed write frame is acknowledged.
- R5: In a read frame, bytes are sent MSB first, starting at the current pointer, and the pointer advances after each byte. Another byte follows whenever the master pulls the ninth bit low.
- R6: When the master leaves the ninth bit of a read byte high, the block releases the data line and does not drive it again before the next START.
- R7: The pointer wraps from REG_COUNT-1 to 0, on both reads and writes.
- R8: After reset the data line is released, all registers read 0x00 and the pointer is 0. The data line is only ever pulled low, through sda_oe_o.
- R9: The pointer keeps its value from one frame to the next. A read frame that is not preceded by a pointer write starts where the previous frame left off.
- R10: The block operates correctly with bus clock periods of both 32 and 120 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
Write frames carry a pointer byte followed by data bytes. Read frames are checked against a bench model of the register bank and the pointer, so the tests tell a stored byte apart from a wrong pointer or a missing increment. Four patterns separate the remaining behaviours:
- Frames that cross the end of the register map test the wrap.
- A foreign address followed by a read-back shows that nothing was acknowledged or stored.
- A pointer write joined to a read by a repeated START tests re-arming without a STOP.
- A final single-byte read whose successor has a low MSB shows whether the line stays released after the master declines more data.

The same frames run at a fast and at a slow bus rate.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } twi_state_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_prev;
  logic                   sda_prev;

  // Both lines idle high, so the pipes reset to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[SYNC_STAGES-1];
      sda_prev <= sda_pipe[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  // Frame delimiters: a data edge while the clock is high in both samples.
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
  parameter int REG_COUNT = 8,
  parameter int AW        = 3,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_cell
    logic          cell_en;
    logic [DW-1:0] cell_q;

    assign cell_en = wr_en & (wr_addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
      end else if (cell_en) begin
        cell_q <= wr_data;
      end
    end

    assign cells[i] = cell_q;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h5A,
  parameter int         REG_COUNT = 8,
  parameter int         AW        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sda_s,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 start_det,
  input  logic                 stop_det,
  input  logic [BYTE_BITS-1:0] rd_data,
  output logic [AW-1:0]        rd_addr,
  output logic                 wr_en,
  output logic [AW-1:0]        wr_addr,
  output logic [BYTE_BITS-1:0] wr_data,
  output logic                 sda_oe
);

  localparam logic [AW-1:0] PTR_LAST  = AW'(REG_COUNT - 1);
  localparam logic [AW-1:0] PTR_STEP  = AW'(1);
  localparam logic [3:0]    BIT_FULL  = 4'(BYTE_BITS);
  localparam logic [3:0]    BIT_LAST  = 4'(BYTE_BITS - 1);
  localparam logic [3:0]    BIT_STEP  = 4'd1;

  twi_state_t           state_q,  state_d;
  logic [3:0]           cnt_q,    cnt_d;
  logic [BYTE_BITS-1:0] rx_q,     rx_d;
  logic [BYTE_BITS-1:0] tx_q,     tx_d;
  logic [AW-1:0]        ptr_q,    ptr_d;
  logic                 first_q,  first_d;
  logic                 dir_rd_q, dir_rd_d;
  logic                 mack_q,   mack_d;
  logic                 oe_q,     oe_d;
  logic [AW-1:0]        ptr_inc;
  logic                 addr_hit;

  assign ptr_inc  = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_STEP;
  assign addr_hit = (rx_q[BYTE_BITS-1:1] == DEV_ADDR);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    tx_d     = tx_q;
    ptr_d    = ptr_q;
    first_d  = first_q;
    dir_rd_d = dir_rd_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    wr_en    = 1'b0;

    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      first_d = 1'b1;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_d  = {rx_q[BYTE_BITS-2:0], sda_s};
            cnt_d = cnt_q + BIT_STEP;
          end else if (scl_fall && cnt_q == BIT_FULL) begin
            if (addr_hit) begin
              state_d  = ST_ADDR_ACK;
              dir_rd_d = rx_q[0];
              oe_d     = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (dir_rd_q) begin
              state_d = ST_RD;
              tx_d    = rd_data;
              ptr_d   = ptr_inc;
              oe_d    = ~rd_data[BYTE_BITS-1];
            end else begin
              state_d = ST_WR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            rx_d  = {rx_q[BYTE_BITS-2:0], sda_s};
            cnt_d = cnt_q + BIT_STEP;
          end else if (scl_fall && cnt_q == BIT_FULL) begin
            if (first_q) begin
              ptr_d   = rx_q[AW-1:0];
              first_d = 1'b0;
            end else begin
              wr_en = 1'b1;
              ptr_d = ptr_inc;
            end
            state_d = ST_WR_ACK;
            oe_d    = 1'b1;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == BIT_LAST) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              tx_d  = {tx_q[BYTE_BITS-2:0], 1'b0};
              oe_d  = ~tx_q[BYTE_BITS-2];
              cnt_d = cnt_q + BIT_STEP;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RD;
              cnt_d   = '0;
              tx_d    = rd_data;
              ptr_d   = ptr_inc;
              oe_d    = ~rd_data[BYTE_BITS-1];
            end else begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      ptr_q    <= '0;
      first_q  <= 1'b0;
      dir_rd_q <= 1'b0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      tx_q     <= tx_d;
      ptr_q    <= ptr_d;
      first_q  <= first_d;
      dir_rd_q <= dir_rd_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign rd_addr = ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = rx_q;
  assign sda_oe  = oe_q;

endmodule

// File: rtl/twi_slave_regs.sv
module twi_slave_regs
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h5A,
  parameter int         REG_COUNT   = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);

  localparam int AW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [1:0]           rst_pipe;
  logic                 rst_n_i;
  logic                 scl_s;
  logic                 sda_s;
  logic                 scl_rise;
  logic                 scl_fall;
  logic                 start_det;
  logic                 stop_det;
  logic                 wr_en;
  logic [AW-1:0]        wr_addr;
  logic [AW-1:0]        rd_addr;
  logic [BYTE_BITS-1:0] wr_data;
  logic [BYTE_BITS-1:0] rd_data;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_i = rst_pipe[1];

  twi_line_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_proto_fsm #(
    .DEV_ADDR  (DEV_ADDR),
    .REG_COUNT (REG_COUNT),
    .AW        (AW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  twi_reg_bank #(
    .REG_COUNT (REG_COUNT),
    .AW        (AW),
    .DW        (BYTE_BITS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/twi_slave_chk.sv
module twi_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_s,
  input logic stop_s,
  input logic wr_en,
  input logic sda_oe
);

  // R2: the pull-down never moves while the clock line stays high
  a_r2_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R1: a START leaves the line released while the address is received
  a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_s |=> !sda_oe);

  // R1: a STOP releases the line
  a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_s |=> !sda_oe);

  // R4: every stored byte is followed by an acknowledge pull-down
  a_r4_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R8: the enable is always a defined level
  a_r8_oe_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(sda_oe));

endmodule

bind twi_slave_regs twi_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n_i),
  .scl_s   (scl_s),
  .start_s (start_det),
  .stop_s  (stop_det),
  .wr_en   (wr_en),
  .sda_oe  (sda_oe_o)
);

// File: tb/test_twi_slave_regs.sv
module test_twi_slave_regs;

  localparam int         CLK_PERIOD = 10;
  localparam logic [6:0] DEV        = 7'h5A;
  localparam int         NREG       = 8;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_bus;
  logic sda_oe_o;

  int   checks;
  int   errs;
  int   q;
  bit   done;

  logic [7:0] ref_mem [NREG];
  int         ref_ptr;
  logic [7:0] wq [$];

  assign sda_bus = sda_m & ~sda_oe_o;

  twi_slave_regs #(
    .DEV_ADDR  (DEV),
    .REG_COUNT (NREG)
  ) i_twi_slave_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk_oe(input logic exp, input string tag);
    checks++;
    if (sda_oe_o !== exp) begin
      errs++;
      $display("FAIL %s: sda_oe_o=%b expected %b at %0t", tag, sda_oe_o, exp, $time);
    end
  endtask

  task automatic chk_byte(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: byte=%02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One bus bit. The reference drive level is compared on every clock of the
  // high phase (R2: the slave may only move while the clock line is low).
  task automatic bit_cycle(input logic b, input logic exp_oe, input string tag,
                           output logic got);
    wait_q(q);
    sda_m = b;
    wait_q(q);
    scl_m = 1'b1;
    got = 1'b1;
    for (int k = 0; k < 2 * q; k++) begin
      @(negedge clk);
      chk_oe(exp_oe, tag);
      got = sda_bus;
    end
    scl_m = 1'b0;
  endtask

  task automatic start_cond();
    wait_q(q);
    sda_m = 1'b0;
    wait_q(q);
    scl_m = 1'b0;
  endtask

  task automatic rep_start_cond();
    wait_q(q);
    sda_m = 1'b1;
    wait_q(q);
    scl_m = 1'b1;
    for (int k = 0; k < q; k++) begin
      @(negedge clk);
      chk_oe(1'b0, "R1 repeated start");
    end
    sda_m = 1'b0;
    wait_q(q);
    scl_m = 1'b0;
  endtask

  task automatic stop_cond(input string tag);
    wait_q(q);
    sda_m = 1'b0;
    wait_q(q);
    scl_m = 1'b1;
    for (int k = 0; k < q; k++) begin
      @(negedge clk);
      chk_oe(1'b0, tag);
    end
    sda_m = 1'b1;
    for (int k = 0; k < q; k++) begin
      @(negedge clk);
      chk_oe(1'b0, tag);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, tag, got);
    bit_cycle(1'b1, exp_ack, tag, got);
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic give_ack, input string tag);
    logic [7:0] acc;
    logic       got;
    acc = '0;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, ~exp[i], tag, got);
      acc[i] = got;
    end
    chk_byte(acc, exp, tag);
    bit_cycle(~give_ack, 1'b0, tag, got);
  endtask

  // Write frame: address, pointer byte, then the bytes queued in wq.
  task automatic wr_frame(input logic [7:0] ptr, input bit with_stop, input string tag);
    start_cond();
    send_byte({DEV, 1'b0}, 1'b1, "R3 address ack");
    send_byte(ptr, 1'b1, tag);
    ref_ptr = int'(ptr) % NREG;
    foreach (wq[j]) begin
      send_byte(wq[j], 1'b1, tag);
      ref_mem[ref_ptr] = wq[j];
      ref_ptr = (ref_ptr + 1) % NREG;
    end
    wq.delete();
    if (with_stop) stop_cond(tag);
  endtask

  task automatic rd_frame(input int n, input bit rep, input string tag);
    if (rep) rep_start_cond();
    else start_cond();
    send_byte({DEV, 1'b1}, 1'b1, "R3 address ack");
    for (int k = 0; k < n; k++) begin
      recv_byte(ref_mem[ref_ptr], k != n - 1, tag);
      ref_ptr = (ref_ptr + 1) % NREG;
    end
    stop_cond("R6 released after NACK");
  endtask

  initial begin
    checks  = 0;
    errs    = 0;
    done    = 1'b0;
    q       = 8;
    scl_m   = 1'b1;
    sda_m   = 1'b1;
    rst_n   = 1'b0;
    ref_ptr = 0;
    for (int i = 0; i < NREG; i++) ref_mem[i] = 8'h00;

    repeat (5) @(negedge clk);
    chk_oe(1'b0, "R8 released in reset");
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk_oe(1'b0, "R8 released after reset");
    end

    // R8: registers clear, pointer at 0
    rd_frame(2, 1'b0, "R8 reset contents");

    // R4: pointer byte then data bytes
    wq.push_back(8'hA5); wq.push_back(8'h3C); wq.push_back(8'h0F);
    wr_frame(8'h01, 1'b1, "R4 write stream");

    // R1: pointer write joined to a read by a repeated START
    wr_frame(8'h01, 1'b0, "R1 pointer set");
    rd_frame(3, 1'b1, "R1 R5 read after repeated start");

    // R7: write across the top of the map
    wq.push_back(8'h11); wq.push_back(8'h22); wq.push_back(8'h33); wq.push_back(8'h44);
    wr_frame(8'h06, 1'b1, "R7 write wrap");

    // R9: read continues from the retained pointer (now 2)
    rd_frame(3, 1'b0, "R9 retained pointer");

    // R7: read across the top of the map
    wr_frame(8'h06, 1'b0, "R7 pointer set");
    rd_frame(4, 1'b1, "R7 read wrap");

    // R3: foreign address, nothing acknowledged or stored
    start_cond();
    send_byte({7'h3A, 1'b0}, 1'b0, "R3 foreign address");
    send_byte(8'h00, 1'b0, "R3 foreign data");
    send_byte(8'hFF, 1'b0, "R3 foreign data");
    stop_cond("R3 foreign stop");
    start_cond();
    send_byte({7'h5B, 1'b1}, 1'b0, "R3 near-miss address");
    stop_cond("R3 near-miss stop");
    wr_frame(8'h00, 1'b0, "R3 pointer set");
    rd_frame(2, 1'b1, "R3 contents unchanged");

    // R6: last byte NACKed; next register has MSB 0, so a wrongly resumed
    // transmit would pull the line low inside the STOP window
    wr_frame(8'h07, 1'b0, "R6 pointer set");
    rd_frame(1, 1'b1, "R6 single byte");

    // R10: slower bus, period 120 system clocks
    q = 30;
    wq.push_back(8'h80); wq.push_back(8'h01); wq.push_back(8'hC3);
    wr_frame(8'h03, 1'b1, "R10 slow write");
    wr_frame(8'h03, 1'b0, "R10 pointer set");
    rd_frame(3, 1'b1, "R10 slow read");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule